// File: doc/BRIEF.md
# Single-Cycle Integer Control Decoder

This block is the control unit of a one-instruction-per-cycle 32-bit integer datapath. It is purely combinational. Each cycle it takes the instruction word fetched that cycle, together with the equal and less-than flags from the datapath's operand comparator. From these it produces every select line the datapath needs: the immediate format, the register-file write enable, the comparator signedness, the two ALU operand muxes, the ALU function, the data-memory direction, the write-back source and the next-PC source.

The decoder covers six opcode groups: register-register ALU operations, register-immediate ALU operations, word load, word store, the six conditional branches, and the register-indirect jump-and-link. Any other opcode leaves the machine state alone: no register write, no memory write, and the next PC is the sequential one. The decoder first sorts the opcode into a class. It then picks that class's fixed selects from one table, works out the ALU function from funct3 and instruction bit 30, and finally resolves the branch condition against the comparator flags.

Top module: `rvc_ctrl_decoder`

## Requirements
- R1: Opcode 0110011 (register ALU) gives reg_wen=1, a_sel=0 (rs1), b_sel=0 (rs2), mem_wr=0, wb_sel=1 (ALU result), pc_sel=0. alu_sel is taken from funct3 (inst[14:12]) with these codes: 000 gives ADD=0, or SUB=1 when inst[30]=1; 001 SLL=2; 010 SLT=3; 011 SLTU=4; 100 XOR=5; 101 gives SRL=6, or SRA=7 when inst[30]=1; 110 OR=8; 111 AND=9.
- R2: Opcode 0010011 (immediate ALU) gives imm_sel=0 (I format), b_sel=1 (immediate), a_sel=0, reg_wen=1, mem_wr=0, wb_sel=1, pc_sel=0. alu_sel follows the R1 code table, except that funct3 000 always gives ADD whatever the value of inst[30].
- R3: Opcode 0000011 (load word) gives imm_sel=0, a_sel=0, b_sel=1, alu_sel=ADD, mem_wr=0 (read), reg_wen=1, wb_sel=0 (memory data), pc_sel=0.
- R4: Opcode 0100011 (store word) gives imm_sel=1 (S format), a_sel=0, b_sel=1, alu_sel=ADD, mem_wr=1 (write), reg_wen=0, pc_sel=0. wb_sel is a don't-care.
- R5: Opcode 1100011 (branch) gives imm_sel=2 (B format), a_sel=1 (PC), b_sel=1, alu_sel=ADD, reg_wen=0, mem_wr=0, wb_sel=1.
- R6: For a branch, pc_sel=1 (ALU target) only when the condition holds. By funct3: 000 needs br_eq; 001 needs !br_eq; 100 and 110 need br_lt; 101 and 111 need !br_lt. funct3 010 and 011 never branch.
- R7: br_unsigned is 1 only for a branch with funct3 110 or 111, and 0 for every other instruction.
- R8: Opcode 1100111 (jalr) gives imm_sel=0, a_sel=0, b_sel=1, alu_sel=ADD, reg_wen=1, mem_wr=0, wb_sel=2 (PC+4), pc_sel=1, whatever the flags.
- R9: Any other opcode gives reg_wen=0, mem_wr=0 and pc_sel=0, whatever the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| inst | input | 32 | Instruction word of the current cycle |
| br_eq | input | 1 | Comparator: operands are equal |
| br_lt | input | 1 | Comparator: operand A is below operand B |
| imm_sel | output | 2 | Immediate format: 0 I, 1 S, 2 B |
| reg_wen | output | 1 | Register-file write enable |
| br_unsigned | output | 1 | Comparator uses unsigned order |
| a_sel | output | 1 | ALU operand A: 0 rs1, 1 PC |
| b_sel | output | 1 | ALU operand B: 0 rs2, 1 immediate |
| alu_sel | output | 4 | ALU function code (table in R1) |
| mem_wr | output | 1 | Data memory: 0 read, 1 write |
| wb_sel | output | 2 | Write-back source: 0 memory, 1 ALU, 2 PC+4 |
| pc_sel | output | 1 | Next PC: 0 PC+4, 1 ALU result |

## Verification
Random instruction words are drawn over the six valid opcodes and unrecognised ones. The remaining bits are random, including inst[30] and funct3, and the comparator flags are random too. This shows that only the opcode, funct3 and bit 30 steer the outputs, and that the flags affect nothing but the branch target choice. Directed words then separate add from sub and addi with bit 30 set, separate logical from arithmetic right shifts in both ALU groups, and pair each branch funct3 with all four flag combinations. That pairing separates signed from unsigned compares and taken from not taken, and it includes the two reserved branch funct3 values. It also shows that jalr redirects under any flags.

// File: rtl/rvc_pkg.sv
package rvc_pkg;
    localparam int INST_W = 32;
    localparam int OPC_W  = 7;
    localparam int F3_W   = 3;
    localparam int F3_LSB = 12;
    localparam int ALT_BIT = 30;

    localparam logic [OPC_W-1:0] OPC_REG    = 7'b0110011;
    localparam logic [OPC_W-1:0] OPC_IMM    = 7'b0010011;
    localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
    localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
    localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
    localparam logic [OPC_W-1:0] OPC_JALR   = 7'b1100111;

    typedef enum logic [2:0] {
        CLS_REG, CLS_IMM, CLS_LOAD, CLS_STORE, CLS_BRANCH, CLS_JALR, CLS_NONE
    } op_class_e;

    typedef enum logic [1:0] {
        IMMF_I = 2'd0, IMMF_S = 2'd1, IMMF_B = 2'd2
    } imm_fmt_e;

    typedef enum logic [3:0] {
        ALU_ADD = 4'd0, ALU_SUB = 4'd1, ALU_SLL = 4'd2, ALU_SLT = 4'd3,
        ALU_SLTU = 4'd4, ALU_XOR = 4'd5, ALU_SRL = 4'd6, ALU_SRA = 4'd7,
        ALU_OR = 4'd8, ALU_AND = 4'd9
    } alu_fn_e;

    typedef enum logic [1:0] {
        WB_MEM = 2'd0, WB_ALU = 2'd1, WB_PC4 = 2'd2
    } wb_src_e;

    typedef struct packed {
        imm_fmt_e imm;
        logic     reg_we;
        logic     a_pc;
        logic     b_imm;
        logic     mem_wr;
        wb_src_e  wb;
        logic     alu_from_fn;
    } static_ctl_t;

    function automatic op_class_e classify(input logic [OPC_W-1:0] opc);
        case (opc)
            OPC_REG:    return CLS_REG;
            OPC_IMM:    return CLS_IMM;
            OPC_LOAD:   return CLS_LOAD;
            OPC_STORE:  return CLS_STORE;
            OPC_BRANCH: return CLS_BRANCH;
            OPC_JALR:   return CLS_JALR;
            default:    return CLS_NONE;
        endcase
    endfunction

    function automatic alu_fn_e fn_from_f3(input logic [F3_W-1:0] f3, input logic alt);
        case (f3)
            3'b000:  return alt ? ALU_SUB : ALU_ADD;
            3'b001:  return ALU_SLL;
            3'b010:  return ALU_SLT;
            3'b011:  return ALU_SLTU;
            3'b100:  return ALU_XOR;
            3'b101:  return alt ? ALU_SRA : ALU_SRL;
            3'b110:  return ALU_OR;
            default: return ALU_AND;
        endcase
    endfunction
endpackage

// File: rtl/rvc_class_decode.sv
module rvc_class_decode
    import rvc_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output op_class_e        cls
);
    always_comb cls = classify(opcode);
endmodule

// File: rtl/rvc_static_table.sv
module rvc_static_table
    import rvc_pkg::*;
(
    input  op_class_e   cls,
    output static_ctl_t ctl
);
    always_comb begin
        ctl = '{imm: IMMF_I, reg_we: 1'b0, a_pc: 1'b0, b_imm: 1'b0,
                mem_wr: 1'b0, wb: WB_ALU, alu_from_fn: 1'b0};
        case (cls)
            CLS_REG: begin
                ctl.reg_we = 1'b1;
                ctl.alu_from_fn = 1'b1;
            end
            CLS_IMM: begin
                ctl.reg_we = 1'b1;
                ctl.b_imm = 1'b1;
                ctl.alu_from_fn = 1'b1;
            end
            CLS_LOAD: begin
                ctl.reg_we = 1'b1;
                ctl.b_imm = 1'b1;
                ctl.wb = WB_MEM;
            end
            CLS_STORE: begin
                ctl.imm = IMMF_S;
                ctl.b_imm = 1'b1;
                ctl.mem_wr = 1'b1;
            end
            CLS_BRANCH: begin
                ctl.imm = IMMF_B;
                ctl.a_pc = 1'b1;
                ctl.b_imm = 1'b1;
            end
            CLS_JALR: begin
                ctl.reg_we = 1'b1;
                ctl.b_imm = 1'b1;
                ctl.wb = WB_PC4;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rvc_alu_select.sv
module rvc_alu_select
    import rvc_pkg::*;
(
    input  logic            use_fn,
    input  logic            is_reg,
    input  logic [F3_W-1:0] funct3,
    input  logic            alt,
    output alu_fn_e         alu_fn
);
    // For immediate ops, bit 30 belongs to the immediate except on right shifts.
    logic alt_eff;
    always_comb begin
        alt_eff = alt && (is_reg || funct3 == 3'b101);
        alu_fn  = use_fn ? fn_from_f3(funct3, alt_eff) : ALU_ADD;
    end

    always_comb begin
        AST_ADDI_NEVER_SUB: assert (!(use_fn && !is_reg && alu_fn == ALU_SUB))
            else $error("immediate group produced subtract"); // R2
    end
endmodule

// File: rtl/rvc_branch_eval.sv
module rvc_branch_eval
    import rvc_pkg::*;
(
    input  logic            is_branch,
    input  logic [F3_W-1:0] funct3,
    input  logic            eq,
    input  logic            lt,
    output logic            unsigned_cmp,
    output logic            take
);
    logic cond;
    always_comb begin
        case (funct3)
            3'b000:  cond = eq;
            3'b001:  cond = !eq;
            3'b100,
            3'b110:  cond = lt;
            3'b101,
            3'b111:  cond = !lt;
            default: cond = 1'b0;
        endcase
        unsigned_cmp = is_branch && funct3[2] && funct3[1];
        take         = is_branch && cond;
    end

    always_comb begin
        AST_RESERVED_F3_NO_TAKE: assert (!(take && funct3[2:1] == 2'b01))
            else $error("reserved branch funct3 taken"); // R6
    end
endmodule

// File: rtl/rvc_ctrl_decoder.sv
module rvc_ctrl_decoder
    import rvc_pkg::*;
(
    input  logic [INST_W-1:0] inst,
    input  logic              br_eq,
    input  logic              br_lt,
    output logic [1:0]        imm_sel,
    output logic              reg_wen,
    output logic              br_unsigned,
    output logic              a_sel,
    output logic              b_sel,
    output logic [3:0]        alu_sel,
    output logic              mem_wr,
    output logic [1:0]        wb_sel,
    output logic              pc_sel
);
    op_class_e   cls;
    static_ctl_t ctl;
    alu_fn_e     alu_fn;
    logic        take;
    logic        unsigned_cmp;
    logic [F3_W-1:0] funct3;
    logic        unused_fields;

    assign funct3        = inst[F3_LSB +: F3_W];
    assign unused_fields = ^{inst[31], inst[29:15], inst[11:7]};

    rvc_class_decode u_class (
        .opcode (inst[OPC_W-1:0]),
        .cls    (cls)
    );

    rvc_static_table u_table (
        .cls (cls),
        .ctl (ctl)
    );

    rvc_alu_select u_alu (
        .use_fn (ctl.alu_from_fn),
        .is_reg (cls == CLS_REG),
        .funct3 (funct3),
        .alt    (inst[ALT_BIT]),
        .alu_fn (alu_fn)
    );

    rvc_branch_eval u_branch (
        .is_branch    (cls == CLS_BRANCH),
        .funct3       (funct3),
        .eq           (br_eq),
        .lt           (br_lt),
        .unsigned_cmp (unsigned_cmp),
        .take         (take)
    );

    always_comb begin
        imm_sel     = ctl.imm;
        reg_wen     = ctl.reg_we;
        a_sel       = ctl.a_pc;
        b_sel       = ctl.b_imm;
        mem_wr      = ctl.mem_wr;
        wb_sel      = ctl.wb;
        alu_sel     = alu_fn;
        br_unsigned = unsigned_cmp;
        pc_sel      = take || (cls == CLS_JALR);
    end

    always_comb begin
        AST_STORE_NO_REGWRITE: assert (!(mem_wr && reg_wen))
            else $error("memory write with register write"); // R4
        AST_PC_REDIRECT_SOURCE: assert (!pc_sel || inst[6:4] == 3'b110)
            else $error("redirect from non-control opcode"); // R6
        AST_UNSIGNED_ONLY_BRANCH: assert (!br_unsigned || inst[OPC_W-1:0] == OPC_BRANCH)
            else $error("unsigned compare outside branch"); // R7
        AST_PC_OPERAND_BRANCH: assert (!a_sel || inst[OPC_W-1:0] == OPC_BRANCH)
            else $error("PC operand outside branch"); // R5
        AST_UNKNOWN_QUIET: assert (cls != CLS_NONE || (!reg_wen && !mem_wr && !pc_sel))
            else $error("unknown opcode changed state"); // R9
    end
endmodule

// File: tb/rvc_ctrl_decoder_test.sv
module rvc_ctrl_decoder_test;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [31:0] inst;
    logic        br_eq, br_lt;
    logic [1:0]  imm_sel, wb_sel;
    logic        reg_wen, br_unsigned, a_sel, b_sel, mem_wr, pc_sel;
    logic [3:0]  alu_sel;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    rvc_ctrl_decoder uut (
        .inst(inst), .br_eq(br_eq), .br_lt(br_lt), .imm_sel(imm_sel),
        .reg_wen(reg_wen), .br_unsigned(br_unsigned), .a_sel(a_sel),
        .b_sel(b_sel), .alu_sel(alu_sel), .mem_wr(mem_wr), .wb_sel(wb_sel),
        .pc_sel(pc_sel)
    );

    // Packing: {imm[13:12], wen[11], unsigned[10], asel[9], bsel[8], alu[7:4], mwr[3], wb[2:1], pc[0]}
    function automatic logic [3:0] ref_alu(input logic [2:0] f3, input logic b30, input logic imm_grp);
        logic [3:0] r;
        case ({f3, b30})
            4'b0000: r = 4'd0;
            4'b0001: r = imm_grp ? 4'd0 : 4'd1;
            4'b1010: r = 4'd6;
            4'b1011: r = 4'd7;
            default: begin
                case (f3)
                    3'd1: r = 4'd2;  3'd2: r = 4'd3;  3'd3: r = 4'd4;
                    3'd4: r = 4'd5;  3'd6: r = 4'd8;  default: r = 4'd9;
                endcase
            end
        endcase
        return r;
    endfunction

    function automatic logic ref_taken(input logic [2:0] f3, input logic eq, input logic lt);
        case (f3)
            3'd0: return eq;
            3'd1: return !eq;
            3'd4, 3'd6: return lt;
            3'd5, 3'd7: return !lt;
            default: return 1'b0;
        endcase
    endfunction

    task automatic expect_for(input logic [31:0] i, input logic eq, input logic lt,
                              output logic [13:0] exp, output logic [13:0] mask, output string tag);
        logic [2:0] f3;
        f3 = i[14:12];
        mask = 14'h3FFF;
        exp = '0;
        case (i[6:0])
            7'b0110011: begin tag = "R1"; mask[13:12] = 2'b00;
                exp = {2'd0, 1'b1, 1'b0, 1'b0, 1'b0, ref_alu(f3, i[30], 1'b0), 1'b0, 2'd1, 1'b0}; end
            7'b0010011: begin tag = "R2";
                exp = {2'd0, 1'b1, 1'b0, 1'b0, 1'b1, ref_alu(f3, i[30], 1'b1), 1'b0, 2'd1, 1'b0}; end
            7'b0000011: begin tag = "R3";
                exp = {2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd0, 1'b0, 2'd0, 1'b0}; end
            7'b0100011: begin tag = "R4"; mask[2:1] = 2'b00;
                exp = {2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 1'b1, 2'd0, 1'b0}; end
            7'b1100011: begin tag = "R5/R6/R7";
                exp = {2'd2, 1'b0, (f3 == 3'd6 || f3 == 3'd7), 1'b1, 1'b1, 4'd0, 1'b0, 2'd1,
                       ref_taken(f3, eq, lt)}; end
            7'b1100111: begin tag = "R8";
                exp = {2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd0, 1'b0, 2'd2, 1'b1}; end
            default: begin tag = "R9"; mask = 14'b00_1_0_0_0_0000_1_00_1; end
        endcase
    endtask

    task automatic apply_check(input logic [31:0] i, input logic eq, input logic lt);
        logic [13:0] exp, mask, act;
        string tag;
        @(negedge clk);
        inst = i; br_eq = eq; br_lt = lt;
        #2;
        act = {imm_sel, reg_wen, br_unsigned, a_sel, b_sel, alu_sel, mem_wr, wb_sel, pc_sel};
        expect_for(i, eq, lt, exp, mask, tag);
        compared++;
        if ((act & mask) !== (exp & mask)) begin
            mismatched++;
            $display("FAIL %s inst=%h eq=%b lt=%b actual=%b expected=%b mask=%b",
                     tag, i, eq, lt, act, exp, mask);
        end
    endtask

    function automatic logic [31:0] mk(input logic [6:0] opc, input logic [2:0] f3, input logic b30);
        return {1'b0, b30, 5'd3, 5'd2, 5'd1, f3, 5'd4, opc};
    endfunction

    initial begin
        logic [6:0] opcs [7];
        void'($urandom(32'd151));
        inst = 32'h0; br_eq = 1'b0; br_lt = 1'b0;
        opcs = '{7'b0110011, 7'b0010011, 7'b0000011, 7'b0100011, 7'b1100011, 7'b1100111, 7'b0};
        // Idle word (opcode 0000000): R9
        apply_check(32'h0000_0000, 1'b1, 1'b1);
        // R1: add vs sub, srl vs sra, full funct3 sweep
        for (int f = 0; f < 8; f++) begin
            apply_check(mk(7'b0110011, f[2:0], 1'b0), 1'b0, 1'b0);
            apply_check(mk(7'b0110011, f[2:0], 1'b1), 1'b1, 1'b0);
        end
        // R2: addi with bit30 set stays ADD, srli vs srai
        for (int f = 0; f < 8; f++) begin
            apply_check(mk(7'b0010011, f[2:0], 1'b1), 1'b0, 1'b1);
            apply_check(mk(7'b0010011, f[2:0], 1'b0), 1'b1, 1'b1);
        end
        // R3, R4
        apply_check(mk(7'b0000011, 3'd2, 1'b1), 1'b1, 1'b0);
        apply_check(mk(7'b0100011, 3'd2, 1'b0), 1'b0, 1'b1);
        // R5 R6 R7: every branch funct3 with every flag pair, including reserved 010/011
        for (int f = 0; f < 8; f++)
            for (int k = 0; k < 4; k++)
                apply_check(mk(7'b1100011, f[2:0], 1'b0), k[1], k[0]);
        // R8: jalr redirects under all flags
        for (int k = 0; k < 4; k++)
            apply_check(mk(7'b1100111, 3'd0, k[0]), k[1], k[0]);
        // R9: near-miss opcodes
        apply_check(mk(7'b1101111, 3'd0, 1'b0), 1'b1, 1'b1);
        apply_check(mk(7'b0110111, 3'd0, 1'b0), 1'b0, 1'b1);
        apply_check(mk(7'b1110011, 3'd6, 1'b1), 1'b1, 1'b0);
        // Random mix across all groups
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] w;
            w = $urandom;
            if ($urandom_range(0, 6) != 6) w[6:0] = opcs[$urandom_range(0, 5)];
            apply_check(w, 1'($urandom), 1'($urandom));
        end
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule